// File: doc/BRIEF.md
# Random Generator Register Front End

This block is the software-facing register file of a hardware random number generator. A processor reaches it over a simple 32-bit word bus with a one-cycle write strobe and a combinational read port. An external entropy source hands it 32-bit words with a valid flag. The block also receives a seed-error level and a clock-error level from that source. Accepted words wait in a small in-order pipeline until software reads them from the data register. A data-ready flag reports that a word is waiting.

Configuration for the source covers the entropy selection fields, the clock-divider exponent and clock-error detection. It only takes effect when it comes in the same control write that raises the conditioning-reset bit. Releasing that bit starts a fixed internal reset sequence, and the bit reads back as set until the sequence is over. Seed errors have a live flag and a sticky interrupt flag. The live flag either follows the source back to health by itself or waits for a conditioning reset, as selected by a control bit. A lock bit freezes the configuration, the noise-source register and the health-test register until hardware reset.

Byte offsets: control 0x00, status 0x04, data 0x08, noise-source 0x0C, health-test 0x10.

Top module: `rng_regfile`

## Requirements
- R1: After reset the control register reads 0x0000_0F00 (default entropy field 11:8 = 0xF, everything else 0), status reads 0, data reads 0, the noise-source register reads 0x2_AAAA and the health-test register reads 0x0000_AAC7.
- R2: An entropy word is taken only when the enable bit (control bit 2) is 1, no seed error is live and no conditioning reset is in progress. Words come out of the data register in arrival order. Status bit 0 is 1 while a word waits, and it clears on the read that empties the pipeline.
- R3: The pipeline holds 4 words. Words that arrive while it is full are dropped.
- R4: Reading the data register with no valid word waiting returns 0. This includes a read during a seed error or a conditioning reset.
- R5: Control bit 5 and bits 25:8 change only on a write that also sets bit 30. On any other write they keep their value.
- R6: A write that sets bit 30 is rejected if the entropy fields (bits 25:20 and 15:8) are all zero. In that case bit 5 and bits 25:8 keep their previous values.
- R7: Control bit 30 reads 1 from the write that sets it. After the write that clears it, it still reads 1 for 16 more cycles and then reads 0. No entropy word is taken while it reads 1, and the pipeline is emptied.
- R8: A seed error while enabled sets status bit 2 (live) and bit 6 (sticky). It empties the pipeline, stops word intake and raises irq_o.
- R9: With control bit 4 = 0, status bit 2 stays set until a conditioning reset completes. It then clears, while bit 6 stays set.
- R10: With control bit 4 = 1, status bit 2 clears in the first cycle the seed-error input is low. Bit 6 stays set.
- R11: Writing 0 to status bit 5 or bit 6 clears it, and writing 1 leaves it unchanged. Status bits 0, 1 and 2 ignore writes. irq_o is the OR of bits 5 and 6.
- R12: With control bit 5 = 1, a clock-error input sets status bit 1 one cycle later (for as long as the input lasts) and sets sticky bit 5. With control bit 5 = 0 the input has no effect.
- R13: The noise-source register stores only bits 17:0. Its bits 31:18 read 0.
- R14: Once control bit 31 is written 1 it stays 1 until reset. While it is 1, configuration applies, noise-source writes and health-test writes are ignored. The enable and self-clear bits remain writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read access |
| ent_valid_i | input | 1 | Entropy word valid |
| ent_word_i | input | 32 | Entropy word |
| seed_err_i | input | 1 | Seed error level from the source |
| clk_err_i | input | 1 | Clock error level from the source |
| gen_en_o | output | 1 | Generation allowed |
| cond_rst_o | output | 1 | Conditioning reset in progress |
| cfg_o | output | 32 | Applied configuration (bit 5, bits 25:8) |
| noise_o | output | 18 | Noise-source control value |
| health_o | output | 32 | Health-test value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks the config-without-reset write. A design that applied it would read back the stray fields. It also checks the all-zero entropy apply, which a faulty design would accept and so silence the source. The conditioning bit is sampled on the last busy cycle and again on the first free cycle, so a sequence of 15 or 17 cycles, or a bit that drops at once on release, shows up at the port. Seed-error recovery is run in both modes, and the bench checks that the sticky flag survives each. Words are fed during errors, during conditioning and into a full pipeline, so a design that kept stale words would return them instead of zero.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_STAT   = 1;
  localparam int unsigned IDX_DATA   = 2;
  localparam int unsigned IDX_NOISE  = 3;
  localparam int unsigned IDX_HEALTH = 4;

  localparam int unsigned C_EN   = 2;
  localparam int unsigned C_HEAL = 4;
  localparam int unsigned C_CED  = 5;
  localparam int unsigned C_COND = 30;
  localparam int unsigned C_LOCK = 31;

  localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;
  localparam logic [31:0] ENT_MASK = 32'h03F0_FF00;

  localparam int unsigned S_RDY  = 0;
  localparam int unsigned S_CCUR = 1;
  localparam int unsigned S_SCUR = 2;
  localparam int unsigned S_CIRQ = 5;
  localparam int unsigned S_SIRQ = 6;

  localparam int unsigned NOISE_W = 18;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic noise;
    logic health;
  } wr_sel_t;
endpackage

// File: rtl/rng_ctrl_reg.sv
module rng_ctrl_reg
  import rng_pkg::*;
#(
  parameter logic [31:0] CFG_RST     = 32'h0000_0F00,
  parameter int unsigned COND_CYCLES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_o,
  output logic [31:0] cfg_o,
  output logic        en_o,
  output logic        heal_o,
  output logic        ced_o,
  output logic        lock_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int unsigned CW = $clog2(COND_CYCLES + 1);

  logic [31:0]   cfg_q;
  logic          en_q, heal_q, lock_q, hold_q;
  logic [CW-1:0] cnt_q;
  logic          apply, raise, release_w;

  assign raise     = wr_i && wdata_i[C_COND];
  assign release_w = wr_i && !wdata_i[C_COND] && hold_q;
  assign apply     = raise && !lock_q && ((wdata_i & ENT_MASK) != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST & CFG_MASK;
      en_q   <= 1'b0;
      heal_q <= 1'b0;
      lock_q <= 1'b0;
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (apply) cfg_q <= wdata_i & CFG_MASK;
      if (wr_i) begin
        en_q   <= wdata_i[C_EN];
        heal_q <= wdata_i[C_HEAL];
        lock_q <= lock_q | wdata_i[C_LOCK];
        hold_q <= wdata_i[C_COND];
      end
      if (raise)                cnt_q <= '0;
      else if (release_w)       cnt_q <= CW'(COND_CYCLES);
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = hold_q || (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !raise;
  assign cfg_o  = cfg_q;
  assign en_o   = en_q;
  assign heal_o = heal_q;
  assign ced_o  = cfg_q[C_CED];
  assign lock_o = lock_q;

  always_comb begin
    ctrl_o         = cfg_q;
    ctrl_o[C_EN]   = en_q;
    ctrl_o[C_HEAL] = heal_q;
    ctrl_o[C_COND] = busy_o;
    ctrl_o[C_LOCK] = lock_q;
  end

  a_r14_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);
  a_r7_release_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_w |=> busy_o);
  a_r5_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[C_COND]) |=> $stable(cfg_o));
  a_r14_lock_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> $stable(cfg_o));
endmodule

// File: rtl/rng_status.sv
module rng_status
  import rng_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        en_i,
  input  logic        heal_i,
  input  logic        ced_i,
  input  logic        seed_err_i,
  input  logic        clk_err_i,
  input  logic        done_i,
  input  logic        rdy_i,
  output logic [31:0] stat_o,
  output logic        secs_o,
  output logic        irq_o
);
  logic secs_q, seis_q, cecs_q, ceis_q;
  logic seed_evt, clk_evt;

  assign seed_evt = seed_err_i && en_i;
  assign clk_evt  = clk_err_i && ced_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q <= 1'b0;
      seis_q <= 1'b0;
      cecs_q <= 1'b0;
      ceis_q <= 1'b0;
    end else begin
      if (seed_evt)                  secs_q <= 1'b1;
      else if (done_i)               secs_q <= 1'b0;
      else if (heal_i && !seed_err_i) secs_q <= 1'b0;

      if (seed_evt)                     seis_q <= 1'b1;
      else if (wr_i && !wdata_i[S_SIRQ]) seis_q <= 1'b0;

      cecs_q <= clk_evt;
      if (clk_evt)                      ceis_q <= 1'b1;
      else if (wr_i && !wdata_i[S_CIRQ]) ceis_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o         = '0;
    stat_o[S_RDY]  = rdy_i;
    stat_o[S_CCUR] = cecs_q;
    stat_o[S_SCUR] = secs_q;
    stat_o[S_CIRQ] = ceis_q;
    stat_o[S_SIRQ] = seis_q;
  end

  assign secs_o = secs_q;
  assign irq_o  = ceis_q | seis_q;

  a_r8_both_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_evt |=> (secs_o && stat_o[S_SIRQ]));
  a_r9_manual_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secs_o && !heal_i && !done_i) |=> secs_o);
  a_r10_heal_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (heal_i && !seed_err_i) |=> !secs_o);
  a_r11_w1_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[S_SIRQ] && stat_o[S_SIRQ]) |=> stat_o[S_SIRQ]);
endmodule

// File: rtl/rng_pipe.sv
module rng_pipe #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = empty_o ? '0 : mem_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r3_full_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i && !flush_i) |=> full_o);
  a_r2_pop_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1) && pop_i && !push_i && !flush_i) |=> empty_o);
endmodule

// File: rtl/rng_regfile.sv
module rng_regfile
  import rng_pkg::*;
#(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned COND_CYCLES = 16,
  parameter logic [31:0] CFG_RST     = 32'h0000_0F00,
  parameter logic [17:0] NOISE_RST   = 18'h2_AAAA,
  parameter logic [31:0] HEALTH_RST  = 32'h0000_AAC7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        ent_valid_i,
  input  logic [31:0] ent_word_i,
  input  logic        seed_err_i,
  input  logic        clk_err_i,
  output logic        gen_en_o,
  output logic        cond_rst_o,
  output logic [31:0] cfg_o,
  output logic [17:0] noise_o,
  output logic [31:0] health_o,
  output logic        irq_o
);
  function automatic logic hit(input logic [4:0] a, input int unsigned idx);
    return a == 5'(idx * 4);
  endfunction

  wr_sel_t        wsel;
  logic           rd_data;
  logic [31:0]    ctrl_rd, stat_rd, pipe_dout;
  logic           en, heal, ced, lock, busy, done, secs;
  logic           empty, full, push, flush;
  logic [NOISE_W-1:0] noise_q;
  logic [31:0]    health_q;

  assign wsel.ctrl   = req_i && we_i && hit(addr_i, IDX_CTRL);
  assign wsel.stat   = req_i && we_i && hit(addr_i, IDX_STAT);
  assign wsel.noise  = req_i && we_i && hit(addr_i, IDX_NOISE);
  assign wsel.health = req_i && we_i && hit(addr_i, IDX_HEALTH);
  assign rd_data     = req_i && !we_i && hit(addr_i, IDX_DATA);

  rng_ctrl_reg #(.CFG_RST(CFG_RST), .COND_CYCLES(COND_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i   (wsel.ctrl),
    .wdata_i,
    .ctrl_o (ctrl_rd),
    .cfg_o,
    .en_o   (en),
    .heal_o (heal),
    .ced_o  (ced),
    .lock_o (lock),
    .busy_o (busy),
    .done_o (done)
  );

  rng_status u_stat (
    .clk_i, .rst_ni,
    .wr_i       (wsel.stat),
    .wdata_i,
    .en_i       (en),
    .heal_i     (heal),
    .ced_i      (ced),
    .seed_err_i,
    .clk_err_i,
    .done_i     (done),
    .rdy_i      (!empty && !flush),
    .stat_o     (stat_rd),
    .secs_o     (secs),
    .irq_o
  );

  assign gen_en_o   = en && !secs && !busy;
  assign cond_rst_o = busy;
  assign flush      = secs || busy;
  assign push       = ent_valid_i && gen_en_o;

  rng_pipe #(.DW(32), .DEPTH(DEPTH)) u_pipe (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (ent_word_i),
    .pop_i   (rd_data),
    .flush_i (flush),
    .dout_o  (pipe_dout),
    .empty_o (empty),
    .full_o  (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      noise_q  <= NOISE_RST;
      health_q <= HEALTH_RST;
    end else begin
      if (wsel.noise && !lock)  noise_q  <= wdata_i[NOISE_W-1:0];
      if (wsel.health && !lock) health_q <= wdata_i;
    end
  end

  assign noise_o  = noise_q;
  assign health_o = health_q;

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit(addr_i, IDX_CTRL))   rdata_o = ctrl_rd;
      if (hit(addr_i, IDX_STAT))   rdata_o = stat_rd;
      if (hit(addr_i, IDX_DATA))   rdata_o = flush ? '0 : pipe_dout;
      if (hit(addr_i, IDX_NOISE))  rdata_o = 32'(noise_q);
      if (hit(addr_i, IDX_HEALTH)) rdata_o = health_q;
    end
  end

  a_r7_no_intake_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_rst_o |-> !push);
  a_r8_no_intake_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd[S_SCUR] |-> !gen_en_o);
  a_r13_noise_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hit(addr_i, IDX_NOISE)) |-> (rdata_o[31:18] == '0));
  a_r14_noise_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock && wsel.noise) |=> $stable(noise_o));
  a_r4_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && empty) |-> (rdata_o == '0));
endmodule

// File: tb/test_rng_regfile.sv
module test_rng_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ent_valid = 1'b0;
  logic [31:0] ent_word = '0;
  logic        seed_err = 1'b0, clk_err = 1'b0;
  logic        gen_en, cond_rst, irq;
  logic [31:0] cfg, health;
  logic [17:0] noise;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] model_q [$];

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_DATA = 5'h08,
                         A_NOISE = 5'h0C, A_HEALTH = 5'h10;

  always #5 clk = ~clk;

  rng_regfile i_rng_regfile (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ent_valid_i(ent_valid),
    .ent_word_i(ent_word), .seed_err_i(seed_err), .clk_err_i(clk_err),
    .gen_en_o(gen_en), .cond_rst_o(cond_rst), .cfg_o(cfg), .noise_o(noise),
    .health_o(health), .irq_o(irq)
  );

  function automatic logic [31:0] mk_ctrl(input logic [31:0] c, input logic en,
                                          input logic heal, input logic busy,
                                          input logic lock);
    logic [31:0] v;
    v = c & 32'h03FF_FF20;
    v[2] = en; v[4] = heal; v[30] = busy; v[31] = lock;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic feed(input logic [31:0] w);
    ent_valid = 1'b1; ent_word = w;
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  task automatic cond_apply(input logic [31:0] c);
    bus_wr(A_CTRL, c | 32'h4000_0004);
    bus_wr(A_CTRL, c | 32'h0000_0004);
    repeat (17) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cfg_a, cfg_b;
    void'($urandom(32'd41));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_CTRL, d);   chk("R1 ctrl", d, 32'h0000_0F00);
    bus_rd(A_STAT, d);   chk("R1 stat", d, 32'h0);
    bus_rd(A_DATA, d);   chk("R1 data", d, 32'h0);
    bus_rd(A_NOISE, d);  chk("R1 noise", d, 32'h0002_AAAA);
    bus_rd(A_HEALTH, d); chk("R1 health", d, 32'h0000_AAC7);

    // R2 intake needs enable
    feed(32'h1111_2222);
    bus_rd(A_STAT, d); chk("R2 disabled no data", d, 32'h0);
    bus_wr(A_CTRL, 32'h0000_0004);
    bus_rd(A_CTRL, d); chk("R5 enable only", d, mk_ctrl(32'h0F00, 1, 0, 0, 0));
    feed(32'hCAFE_0001);
    bus_rd(A_STAT, d); chk("R2 ready set", d, 32'h1);
    bus_rd(A_DATA, d); chk("R2 word out", d, 32'hCAFE_0001);
    bus_rd(A_STAT, d); chk("R2 ready clear", d, 32'h0);

    // R3 depth and drop, R4 empty read
    for (int i = 0; i < 6; i++) feed(32'hA000_0000 + i);
    for (int i = 0; i < 4; i++) begin
      bus_rd(A_DATA, d); chk("R3 order", d, 32'hA000_0000 + i);
    end
    bus_rd(A_DATA, d); chk("R4 empty zero", d, 32'h0);

    // R2 R3 random mix against a queue model
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(1, 0) == 1) begin
        logic [31:0] w;
        w = $urandom() | 32'h1;
        feed(w);
        if (model_q.size() < 4) model_q.push_back(w);
      end else begin
        bus_rd(A_DATA, d);
        chk("R2 random read", d, (model_q.size() != 0) ? model_q.pop_front() : 32'h0);
      end
    end
    while (model_q.size() != 0) begin
      bus_rd(A_DATA, d); chk("R2 drain", d, model_q.pop_front());
    end

    // R5 stray config ignored
    bus_wr(A_CTRL, 32'h0123_4524);
    bus_rd(A_CTRL, d); chk("R5 no apply", d, mk_ctrl(32'h0F00, 1, 0, 0, 0));

    // R5 apply, R7 timing and intake block
    cfg_a = 32'h0255_3120;
    bus_wr(A_CTRL, cfg_a | 32'h4000_0004);
    bus_rd(A_CTRL, d); chk("R5 applied", d, mk_ctrl(cfg_a, 1, 0, 1, 0));
    feed(32'h7777_0000);
    bus_wr(A_CTRL, cfg_a | 32'h0000_0004);
    repeat (15) @(negedge clk);
    bus_rd(A_CTRL, d); chk("R7 busy last", d, mk_ctrl(cfg_a, 1, 0, 1, 0));
    bus_rd(A_CTRL, d); chk("R7 busy over", d, mk_ctrl(cfg_a, 1, 0, 0, 0));
    bus_rd(A_STAT, d); chk("R7 no intake", d, 32'h0);

    // R6 zero entropy rejected
    bus_wr(A_CTRL, 32'h400F_0004);
    bus_wr(A_CTRL, 32'h0000_0004);
    repeat (17) @(negedge clk);
    bus_rd(A_CTRL, d); chk("R6 rejected", d, mk_ctrl(cfg_a, 1, 0, 0, 0));

    // R12 clock error detected, R11 clear semantics
    clk_err = 1'b1; @(negedge clk); clk_err = 1'b0;
    bus_rd(A_STAT, d); chk("R12 live and sticky", d, 32'h22);
    bus_rd(A_STAT, d); chk("R12 live drops", d, 32'h20);
    chk("R11 irq", {31'h0, irq}, 32'h1);
    bus_wr(A_STAT, 32'hFFFF_FFFF);
    bus_rd(A_STAT, d); chk("R11 w1 keeps", d, 32'h20);
    bus_wr(A_STAT, 32'h0);
    bus_rd(A_STAT, d); chk("R11 w0 clears", d, 32'h0);
    chk("R11 irq low", {31'h0, irq}, 32'h0);

    // R12 detection off
    cfg_b = cfg_a & ~32'h20;
    cond_apply(cfg_b);
    clk_err = 1'b1; @(negedge clk); clk_err = 1'b0;
    bus_rd(A_STAT, d); chk("R12 ignored", d, 32'h0);

    // R8 R9 manual recovery
    feed(32'h5555_0001); feed(32'h5555_0002);
    seed_err = 1'b1; @(negedge clk); seed_err = 1'b0;
    @(negedge clk);
    bus_rd(A_STAT, d); chk("R8 flags and flush", d, 32'h44);
    chk("R8 irq", {31'h0, irq}, 32'h1);
    feed(32'h5555_0003);
    bus_rd(A_DATA, d); chk("R4 data zero on error", d, 32'h0);
    repeat (5) @(negedge clk);
    bus_rd(A_STAT, d); chk("R9 live held", d, 32'h44);
    cond_apply(cfg_b);
    bus_rd(A_STAT, d); chk("R9 cleared by cond", d, 32'h40);
    bus_wr(A_STAT, 32'h0);

    // R10 self clear
    bus_wr(A_CTRL, 32'h0000_0014);
    seed_err = 1'b1; @(negedge clk); @(negedge clk);
    bus_rd(A_STAT, d); chk("R10 live during", d, 32'h44);
    seed_err = 1'b0; @(negedge clk);
    bus_rd(A_STAT, d); chk("R10 auto clear", d, 32'h40);
    feed(32'h9999_0001);
    bus_rd(A_DATA, d); chk("R10 resumed", d, 32'h9999_0001);
    bus_wr(A_STAT, 32'h0);

    // R13 noise width
    bus_wr(A_NOISE, 32'hFFFF_FFFF);
    bus_rd(A_NOISE, d); chk("R13 noise mask", d, 32'h0003_FFFF);
    bus_wr(A_HEALTH, 32'h1234_5678);
    bus_rd(A_HEALTH, d); chk("R13 health full", d, 32'h1234_5678);

    // R14 lock
    bus_wr(A_CTRL, 32'h8000_0014);
    cond_apply(32'h0100_0100);
    bus_rd(A_CTRL, d); chk("R14 cfg frozen", d, mk_ctrl(cfg_b, 1, 0, 0, 1));
    bus_wr(A_NOISE, 32'h0);
    bus_rd(A_NOISE, d); chk("R14 noise frozen", d, 32'h0003_FFFF);
    bus_wr(A_HEALTH, 32'h0);
    bus_rd(A_HEALTH, d); chk("R14 health frozen", d, 32'h1234_5678);
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_CTRL, d); chk("R14 lock sticky, enable writable", d, mk_ctrl(cfg_b, 0, 0, 0, 1));
    chk("R14 gen off", {31'h0, gen_en}, 32'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule